// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block produces the strobe and latch-enable waveforms for a single NAND flash bank on a parallel bus. It runs on the system bus clock. A requester hands it one access at a time: a command byte, an address byte, a data write or a data read. For each access the block steps through three phases: setup, strobe and hold. It raises the command or address latch enable for the whole access. It pulls the write strobe or the read strobe low only while the strobe phase lasts.

Two sets of phase lengths are provided. The access's space bit chooses between them: common memory or attribute. Two gap fields stretch the setup of the first data read that follows a command or address access. This lets the device settle before the read strobe falls. The device's active-low wait line goes through a two-stage synchronizer, and when the bank's wait-enable input is set it can lengthen the strobe phase. All timing inputs are captured when an access is accepted.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, both strobes are high, both latch enables are low and `ready` is low.
- R2: An access is accepted on a clock edge where `req_valid` is high and `busy` is low. Call the selected setup, strobe and hold fields S, W and H, and number the edges after acceptance from 1. The strobe falls at edge S+1 and rises at edge S+W+2. `busy` falls at edge S+W+H+3, and `ready` is high for exactly the one cycle before that edge.
- R3: For a command access (`req_op` = 0) `nand_cle` is high for the whole busy period and `nand_ale` stays low. `nand_we_n` strobes, `nand_re_n` stays high, and `nand_dq_o` carries `req_wdata` with `nand_dq_oe` high.
- R4: An address access (`req_op` = 1) behaves as in R3, with `nand_ale` in place of `nand_cle`.
- R5: A read (`req_op` = 2) strobes `nand_re_n` with `nand_dq_oe` low. `rdata` takes the value on `nand_dq_i` at the edge where `nand_re_n` rises. A write (`req_op` = 3) strobes `nand_we_n` and drives `req_wdata`.
- R6: `req_attr` = 1 selects the attribute fields `att_*`, and 0 selects the common-memory fields `mem_*`. The fields of the space not selected have no effect.
- R7: For the first read accepted after a command access, `nand_re_n` falls no earlier than `cle_dly` + S + 2 edges after `nand_cle` falls. When the read is requested at once, it falls exactly then. In that case the strobe falls at edge `cle_dly`+S+1 after acceptance.
- R8: R7 applies equally with `ale_dly` when the last command or address access was an address access.
- R9: A write accepted between the command or address access and the read cancels the extra gap. That read then follows R2.
- R10: With `wait_en` high, a low level on `nand_wait_n` during the strobe phase keeps the strobe asserted. If `nand_wait_n` is first sampled high at edge A, the strobe rises at edge A+5: two synchronizer stages, then 4 extension cycles.
- R11: With `wait_en` low, `nand_wait_n` has no effect on strobe timing.
- R12: Changing any timing input after acceptance does not alter the access in progress.
- R13: `req_valid` while `busy` is high is ignored. It starts no access and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_op | input | 2 | 0 command, 1 address, 2 read, 3 write |
| req_attr | input | 1 | 1 selects attribute-space timing |
| req_wdata | input | 8 | Byte for command, address or write |
| busy | output | 1 | Access in progress |
| ready | output | 1 | One-cycle pulse in the last hold cycle |
| rdata | output | 8 | Captured read byte |
| mem_set | input | 8 | Common-memory setup length minus one |
| mem_wait | input | 8 | Common-memory strobe length minus one |
| mem_hold | input | 8 | Common-memory hold length minus one |
| att_set | input | 8 | Attribute setup length minus one |
| att_wait | input | 8 | Attribute strobe length minus one |
| att_hold | input | 8 | Attribute hold length minus one |
| cle_dly | input | 4 | Command-to-read gap field |
| ale_dly | input | 4 | Address-to-read gap field |
| wait_en | input | 1 | Honour the device wait line |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_wait_n | input | 1 | Device wait, active low |

## Verification
A corrupted phase counter shows up as a strobe edge that lands on the wrong cycle. The error is visible at the first strobe edge after it occurs, and `busy` then falls on the wrong edge of that same access. A latch-gap flag set in error delays the next read's falling strobe by up to 16 plus S cycles. A flag that is cleared in error makes the read strobe fall at S+1, too early. A stuck synchronizer or stretch state either leaves the read strobe low well past its 5-edge release or ignores the wait line. Both appear within one access.

// File: rtl/nseq_pkg.sv
// Shared types for the NAND strobe sequencer.
// Assumes: op encoding is fixed by the request port (bit 1 set = data access).
package nseq_pkg;
    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_WAIT  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;
endpackage

// File: rtl/nseq_sync.sv
// Multi-stage synchronizer for the asynchronous device wait line.
// Assumes: input idles high; reset value is the idle level.
module nseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            // Single stage: plain capture register.
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '1;
                else        sh <= d;
            end
        end else begin : g_many
            // Shift the sampled level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/nseq_gap_track.sv
// Tracks clocks elapsed since the last command/address access ended and
// whether a data read still owes the latch-to-read gap.
// Assumes: lat_done and data_acc are single-cycle pulses from the FSM.
module nseq_gap_track #(
    parameter int GW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lat_done,
    input  logic          lat_is_ale,
    input  logic          data_acc,
    output logic          pend,
    output logic          pend_ale,
    output logic [GW-1:0] gap
);
    // Restart the gap count at each latch access end; saturate otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_ale <= 1'b0;
            gap      <= '1;
        end else if (lat_done) begin
            pend     <= 1'b1;
            pend_ale <= lat_is_ale;
            gap      <= '0;
        end else begin
            if (data_acc) pend <= 1'b0;
            if (gap != '1) gap <= gap + GW'(1);
        end
    end
endmodule

// File: rtl/nseq_phase_fsm.sv
// Setup / strobe / hold sequencer for one NAND access.
// Assumes: wait_sync_n is already synchronized; timing fields are captured
// at acceptance; wait field >= 4 plus device wait latency when wait_en is used.
module nseq_phase_fsm
    import nseq_pkg::*;
#(
    parameter int TW  = 8,
    parameter int DLW = 4,
    parameter int DW  = 8,
    parameter int GW  = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_op,
    input  logic           req_attr,
    input  logic [DW-1:0]  req_wdata,
    input  logic [TW-1:0]  mem_set,
    input  logic [TW-1:0]  mem_wait,
    input  logic [TW-1:0]  mem_hold,
    input  logic [TW-1:0]  att_set,
    input  logic [TW-1:0]  att_wait,
    input  logic [TW-1:0]  att_hold,
    input  logic [DLW-1:0] cle_dly,
    input  logic [DLW-1:0] ale_dly,
    input  logic           wait_en,
    input  logic           wait_sync_n,
    input  logic [DW-1:0]  dq_i,
    input  logic           lat_pend,
    input  logic           lat_ale,
    input  logic [GW-1:0]  gap_cnt,
    output logic           busy,
    output logic           ready,
    output logic [DW-1:0]  rdata,
    output logic           cle,
    output logic           ale,
    output logic           we_n,
    output logic           re_n,
    output logic [DW-1:0]  dq_o,
    output logic           dq_oe,
    output logic           lat_done,
    output logic           data_acc
);
    localparam int CW = TW + 1;
    localparam logic [CW-1:0] EXT = CW'(4);

    phase_e         phase;
    op_e            op_q;
    logic [CW-1:0]  cnt;
    logic [TW-1:0]  wait_q, hold_q;
    logic [GW-1:0]  tgt_q;
    logic           gate_q, wen_q;
    logic [DW-1:0]  wdata_q;

    logic [TW-1:0]  sel_set, sel_wait, sel_hold;
    logic [DLW-1:0] sel_dly;
    logic           stall, accept;

    // Pick the timing set of the requested space and the pending gap field.
    always_comb begin
        sel_set  = req_attr ? att_set  : mem_set;
        sel_wait = req_attr ? att_wait : mem_wait;
        sel_hold = req_attr ? att_hold : mem_hold;
        sel_dly  = lat_ale  ? ale_dly  : cle_dly;
    end

    assign accept = (phase == PH_IDLE) && req_valid;
    assign stall  = wen_q && !wait_sync_n;

    // Phase sequencing, field capture and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            op_q    <= OP_CMD;
            cnt     <= '0;
            wait_q  <= '0;
            hold_q  <= '0;
            tgt_q   <= '0;
            gate_q  <= 1'b0;
            wen_q   <= 1'b0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (req_valid) begin
                    phase   <= PH_SETUP;
                    op_q    <= op_e'(req_op);
                    wdata_q <= req_wdata;
                    cnt     <= CW'(sel_set) + CW'(1);
                    wait_q  <= sel_wait;
                    hold_q  <= sel_hold;
                    wen_q   <= wait_en;
                    gate_q  <= (op_e'(req_op) == OP_READ) && lat_pend;
                    tgt_q   <= GW'(sel_dly) + GW'(sel_set) + GW'(1);
                end
                PH_SETUP: begin
                    if (cnt > CW'(1)) cnt <= cnt - CW'(1);
                    else if (!gate_q || gap_cnt >= tgt_q) begin
                        phase <= PH_WAIT;
                        cnt   <= CW'(wait_q) + CW'(1);
                    end
                end
                PH_WAIT: begin
                    if (stall) cnt <= (cnt > EXT) ? cnt - CW'(1) : EXT;
                    else if (cnt > CW'(1)) cnt <= cnt - CW'(1);
                    else begin
                        phase <= PH_HOLD;
                        cnt   <= CW'(hold_q) + CW'(1);
                        if (op_q == OP_READ) rdata <= dq_i;
                    end
                end
                default: begin
                    if (cnt > CW'(1)) cnt <= cnt - CW'(1);
                    else phase <= PH_IDLE;
                end
            endcase
        end
    end

    // Drive pins and handshake from the registered phase.
    always_comb begin
        busy     = (phase != PH_IDLE);
        ready    = (phase == PH_HOLD) && (cnt == CW'(1));
        cle      = busy && (op_q == OP_CMD);
        ale      = busy && (op_q == OP_ADDR);
        we_n     = !((phase == PH_WAIT) && (op_q != OP_READ));
        re_n     = !((phase == PH_WAIT) && (op_q == OP_READ));
        dq_oe    = busy && (op_q != OP_READ);
        dq_o     = wdata_q;
        lat_done = ready && (op_q == OP_CMD || op_q == OP_ADDR);
        data_acc = accept && req_op[1];
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (we_n && re_n && !cle && !ale && !ready));
    // R2
    ready_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !busy);
    // R7
    gap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(re_n) && gate_q) |-> (gap_cnt >= tgt_q));
    // R10
    stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && phase == PH_WAIT) |=> (phase == PH_WAIT));
    // R13
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready && req_valid) |=> ($stable(op_q) && busy));
endmodule

// File: rtl/nand_strobe_seq.sv
// Top of the NAND bus timing sequencer: wait-line synchronizer, latch-gap
// tracker and phase FSM. Assumes one bank and one outstanding access.
module nand_strobe_seq #(
    parameter int TW      = 8,
    parameter int DLW     = 4,
    parameter int DW      = 8,
    parameter int SYNC_ST = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_op,
    input  logic           req_attr,
    input  logic [DW-1:0]  req_wdata,
    output logic           busy,
    output logic           ready,
    output logic [DW-1:0]  rdata,
    input  logic [TW-1:0]  mem_set,
    input  logic [TW-1:0]  mem_wait,
    input  logic [TW-1:0]  mem_hold,
    input  logic [TW-1:0]  att_set,
    input  logic [TW-1:0]  att_wait,
    input  logic [TW-1:0]  att_hold,
    input  logic [DLW-1:0] cle_dly,
    input  logic [DLW-1:0] ale_dly,
    input  logic           wait_en,
    output logic           nand_cle,
    output logic           nand_ale,
    output logic           nand_we_n,
    output logic           nand_re_n,
    output logic [DW-1:0]  nand_dq_o,
    output logic           nand_dq_oe,
    input  logic [DW-1:0]  nand_dq_i,
    input  logic           nand_wait_n
);
    localparam int GW = TW + 2;

    logic          wait_sync_n;
    logic          lat_pend, lat_ale, lat_done, data_acc;
    logic [GW-1:0] gap_cnt;

    nseq_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(nand_wait_n), .q(wait_sync_n)
    );

    nseq_gap_track #(.GW(GW)) u_gap (
        .clk(clk), .rst_n(rst_n), .lat_done(lat_done), .lat_is_ale(nand_ale),
        .data_acc(data_acc), .pend(lat_pend), .pend_ale(lat_ale), .gap(gap_cnt)
    );

    nseq_phase_fsm #(.TW(TW), .DLW(DLW), .DW(DW), .GW(GW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_attr(req_attr),
        .req_wdata(req_wdata),
        .mem_set(mem_set), .mem_wait(mem_wait), .mem_hold(mem_hold),
        .att_set(att_set), .att_wait(att_wait), .att_hold(att_hold),
        .cle_dly(cle_dly), .ale_dly(ale_dly), .wait_en(wait_en),
        .wait_sync_n(wait_sync_n), .dq_i(nand_dq_i),
        .lat_pend(lat_pend), .lat_ale(lat_ale), .gap_cnt(gap_cnt),
        .busy(busy), .ready(ready), .rdata(rdata),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .dq_o(nand_dq_o), .dq_oe(nand_dq_oe),
        .lat_done(lat_done), .data_acc(data_acc)
    );
endmodule

// File: tb/sim_nand_strobe_seq.sv
// Self-checking bench: vector table walk, then directed gap, wait-line,
// field-capture and busy-request tests.
module sim_nand_strobe_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic       req_attr = 1'b0;
    logic [7:0] req_wdata = 8'h00;
    logic       busy, ready;
    logic [7:0] rdata;
    logic [7:0] mem_set = 0, mem_wait = 0, mem_hold = 0;
    logic [7:0] att_set = 0, att_wait = 0, att_hold = 0;
    logic [3:0] cle_dly = 0, ale_dly = 0;
    logic       wait_en = 1'b0;
    logic       nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_o;
    logic [7:0] nand_dq_i = 8'h00;
    logic       nand_wait_n = 1'b1;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    nand_strobe_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_attr(req_attr), .req_wdata(req_wdata), .busy(busy), .ready(ready),
        .rdata(rdata), .mem_set(mem_set), .mem_wait(mem_wait), .mem_hold(mem_hold),
        .att_set(att_set), .att_wait(att_wait), .att_hold(att_hold),
        .cle_dly(cle_dly), .ale_dly(ale_dly), .wait_en(wait_en),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_wait_n(nand_wait_n)
    );

    // {op[1:0], attr, set[3:0], wait[3:0], hold[3:0], data[7:0]}
    localparam logic [22:0] VEC [6] = '{
        {2'd0, 1'b0, 4'd1, 4'd2, 4'd1, 8'h70},
        {2'd1, 1'b0, 4'd0, 4'd0, 4'd0, 8'h05},
        {2'd3, 1'b1, 4'd2, 4'd3, 4'd2, 8'hA5},
        {2'd2, 1'b0, 4'd3, 4'd1, 4'd2, 8'h3C},
        {2'd2, 1'b1, 4'd0, 4'd4, 4'd0, 8'hC3},
        {2'd3, 1'b0, 4'd4, 4'd0, 4'd3, 8'h5A}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One access; ef/er/ee are expected strobe-fall, strobe-rise and end edges.
    task automatic access(input logic [1:0] op, input logic attr, input int s,
                          input int w, input int h, input logic [7:0] d,
                          input bit scr, input bit poke, input int lf, input int lt,
                          input string tag, input int ef, input int er, input int ee);
        int fall = -1, rise = -1, endn = -1, rdy_n = -1, rdy_cnt = 0, n = 0;
        bit latch_ok = 1, dq_ok = 1, other_ok = 1;
        logic strobe, other;
        @(negedge clk);
        mem_set  = attr ? 8'd2 : 8'(s);
        mem_wait = attr ? 8'd3 : 8'(w);
        mem_hold = attr ? 8'd1 : 8'(h);
        att_set  = attr ? 8'(s) : 8'd3;
        att_wait = attr ? 8'(w) : 8'd2;
        att_hold = attr ? 8'(h) : 8'd4;
        nand_dq_i = d;
        req_valid = 1'b1; req_op = op; req_attr = attr; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (scr) begin
            mem_set = 8'd7; mem_wait = 8'd7; mem_hold = 8'd7;
            att_set = 8'd7; att_wait = 8'd7; att_hold = 8'd7;
            cle_dly = 4'd9; ale_dly = 4'd9;
        end
        while (n < 400) begin
            @(posedge clk);
            n++;
            #1;
            strobe = (op == 2'd2) ? nand_re_n : nand_we_n;
            other  = (op == 2'd2) ? nand_we_n : nand_re_n;
            if (!other) other_ok = 0;
            if (!strobe && fall < 0) fall = n;
            if (strobe && fall >= 0 && rise < 0) rise = n;
            if (!busy) begin endn = n; break; end
            if (nand_cle != (op == 2'd0) || nand_ale != (op == 2'd1)) latch_ok = 0;
            if (op != 2'd2 && (!nand_dq_oe || nand_dq_o != d)) dq_ok = 0;
            if (op == 2'd2 && nand_dq_oe) dq_ok = 0;
            if (ready) begin rdy_cnt++; rdy_n = n; end
            @(negedge clk);
            nand_wait_n = !(n >= lf && n < lt);
            if (poke && n == 2) begin req_valid = 1'b1; req_op = 2'd2; end
            if (poke && n == 3) req_valid = 1'b0;
        end
        nand_wait_n = 1'b1;
        req_valid = 1'b0;
        chk(fall == ef, {tag, " strobe fall edge"}, fall, ef);
        chk(rise == er, {tag, " strobe rise edge"}, rise, er);
        chk(endn == ee, {tag, " busy end edge"}, endn, ee);
        chk(rdy_cnt == 1 && rdy_n == ee - 1, {tag, " R2 ready pulse"}, rdy_n, ee - 1);
        chk(latch_ok, {tag, " R3 R4 latch enables"}, latch_ok, 1);
        chk(dq_ok, {tag, " R5 data bus drive"}, dq_ok, 1);
        chk(other_ok, {tag, " R5 other strobe idle"}, other_ok, 1);
        if (op == 2'd2) chk(rdata == d, {tag, " R5 read capture"}, rdata, d);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(4 * 150000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !ready && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
            "R1 state in reset", busy, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!busy && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
            "R1 idle after reset", busy, 0);

        // Table walk: R2..R6 over command, address, read, write in both spaces.
        for (int i = 0; i < 6; i++) begin
            automatic logic [22:0] v = VEC[i];
            automatic int s = int'(v[19:16]);
            automatic int w = int'(v[15:12]);
            automatic int h = int'(v[11:8]);
            access(v[22:21], v[20], s, w, h, v[7:0], 0, 0, -1, -1,
                   v[20] ? "R6 R2 vec" : "R2 vec", s + 1, s + w + 2, s + w + h + 3);
        end

        // R7: read right after a command.
        cle_dly = 4'd5; ale_dly = 4'd2;
        access(2'd0, 1'b0, 1, 1, 0, 8'hFF, 0, 0, -1, -1, "R3 cmd", 2, 4, 5);
        access(2'd2, 1'b0, 2, 2, 1, 8'h81, 0, 0, -1, -1, "R7 read", 8, 11, 13);

        // R8: read right after an address, attribute space.
        access(2'd1, 1'b0, 0, 0, 0, 8'h12, 0, 0, -1, -1, "R4 addr", 1, 2, 3);
        access(2'd2, 1'b1, 1, 1, 1, 8'h24, 0, 0, -1, -1, "R8 read", 4, 6, 8);

        // R9: a write in between cancels the gap.
        access(2'd0, 1'b0, 0, 0, 0, 8'h90, 0, 0, -1, -1, "R9 cmd", 1, 2, 3);
        access(2'd3, 1'b0, 0, 0, 0, 8'h11, 0, 0, -1, -1, "R9 write", 1, 2, 3);
        access(2'd2, 1'b0, 1, 1, 0, 8'h42, 0, 0, -1, -1, "R9 read", 2, 4, 5);

        // R10: wait line honoured, released after edge 14 -> rise at 20.
        wait_en = 1'b1;
        access(2'd2, 1'b0, 1, 9, 1, 8'h6B, 0, 0, 3, 14, "R10 read", 2, 20, 22);
        access(2'd3, 1'b1, 1, 9, 0, 8'h6C, 0, 0, 3, 14, "R10 write", 2, 20, 21);

        // R11: same wait pattern, line ignored.
        wait_en = 1'b0;
        access(2'd2, 1'b0, 1, 9, 1, 8'h7D, 0, 0, 3, 14, "R11 read", 2, 12, 14);

        // R12: fields changed right after acceptance.
        cle_dly = 4'd0; ale_dly = 4'd0;
        access(2'd3, 1'b0, 2, 2, 2, 8'hE1, 1, 0, -1, -1, "R12 write", 3, 6, 9);

        // R13: request pulsed while busy is ignored.
        access(2'd3, 1'b0, 1, 3, 1, 8'hB7, 0, 1, -1, -1, "R13 write", 2, 6, 8);
        @(posedge clk); #1;
        chk(!busy && nand_re_n, "R13 no queued access", busy, 0);
        @(posedge clk); #1;
        chk(!busy, "R13 still idle", busy, 0);

        summary();
        $finish;
    end
endmodule